// File: doc/BRIEF.md
# Sub-word Load/Store Memory Stage

This block is the memory-access stage of a 32-bit five-stage pipelined RISC processor. It sits between execute and write-back and is purely combinational. It takes an internal operation code, an effective address, the value to store, the destination register fields and the HI/LO fields from execute. From these it produces the control and data for a 32-bit synchronous data memory: address, chip enable, write enable, a four-bit byte-lane mask and write data. It also produces the fields passed on to write-back.

Memory is big-endian. Byte offset 0 is the most significant lane, bits 31:24. For a store, the block places the byte or halfword on every matching lane of the write data and enables only the addressed lanes. For a load, it takes the addressed byte or halfword out of the returned word and sign-extends or zero-extends it to 32 bits. Any operation code other than the eight load/store codes passes through untouched, with memory left idle.

Top module: `mstage_top`

## Requirements
- R1: While `rst` is high, every output is zero. This includes chip enable, write enable, both register-write flags and a lane mask of 4'b0000.
- R2: An operation code that is not one of the eight codes in R3 is a non-memory operation. Destination, register-write flag, result, HI, LO and HI/LO write pass through unchanged. Chip enable, write enable, lane mask, memory address and write data are all zero.
- R3: The eight memory codes are 8'b111 followed by five low bits. The low bits are 00000 (signed byte load), 00100 (unsigned byte load), 00001 (signed half load), 00101 (unsigned half load), 00011 (word load), 01000 (byte store), 01001 (half store) and 01011 (word store). For each of these codes, chip enable is 1, the memory address equals the effective address, and HI, LO and HI/LO write pass through.
- R4: Byte accesses use the address offset k = addr[1:0]. They enable lane mask 4'b1000 >> k and use data bits [31-8k : 24-8k].
- R5: Halfword accesses use addr[1] and ignore addr[0]. When addr[1] is 0 they use lane mask 4'b1100 and bits 31:16. When addr[1] is 1 they use lane mask 4'b0011 and bits 15:0.
- R6: Word accesses always use lane mask 4'b1111 and ignore addr[1:0].
- R7: Signed loads sign-extend the selected byte or halfword to 32 bits. Unsigned loads zero-extend it.
- R8: A store sets write enable to 1 and the register-write flag out to 0, and passes the result through. Its write data is the low byte repeated four times, the low halfword repeated twice, or the full word.
- R9: A load sets write enable to 0 and the register-write flag out to 1. Its write data is zero, and the result out is the extended load data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Active-high reset; forces all outputs to zero |
| op_i | input | 8 | Internal operation code from execute |
| addr_i | input | 32 | Effective address |
| store_val_i | input | 32 | Register value to store |
| dst_i | input | 5 | Destination register index |
| dst_we_i | input | 1 | Register-write flag from execute |
| result_i | input | 32 | Execute result |
| hi_i | input | 32 | HI value |
| lo_i | input | 32 | LO value |
| hilo_we_i | input | 1 | HI/LO write flag |
| rd_word_i | input | 32 | Word read from data memory |
| dst_o | output | 5 | Destination register index to write-back |
| dst_we_o | output | 1 | Register-write flag to write-back |
| result_o | output | 32 | Result or extended load data |
| hi_o | output | 32 | HI value to write-back |
| lo_o | output | 32 | LO value to write-back |
| hilo_we_o | output | 1 | HI/LO write flag to write-back |
| mem_addr_o | output | 32 | Data memory address |
| mem_ce_o | output | 1 | Data memory chip enable |
| mem_we_o | output | 1 | Data memory write enable |
| mem_lane_o | output | 4 | Byte-lane enable mask, bit 3 = offset 0 |
| mem_wdata_o | output | 32 | Data memory write data |

## Verification
The in-design checks are sampled when combinational values change. They assume the operation code and address are stable across a compare and that reset is a level, not a pulse shorter than the settle time. The bench honours this by changing inputs only on the falling clock edge and reading outputs a quarter period later.

The checks also assume the low address bits matter only for sub-word codes. The stimulus therefore includes word and halfword accesses with nonzero ignored bits, alongside aligned ones.

// File: rtl/mstage_pkg.sv
package mstage_pkg;
  localparam logic [2:0] LS_CLASS = 3'b111;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd3
  } size_e;

  typedef struct packed {
    logic  load;
    logic  store;
    logic  unsgn;
    size_e size;
  } acc_t;
endpackage

// File: rtl/mstage_decode.sv
module mstage_decode
  import mstage_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0] op,
  output acc_t            acc
);
  localparam int CLS_W = 3;

  always_comb begin
    acc = '{load: 1'b0, store: 1'b0, unsgn: 1'b0, size: SZ_WORD};
    if (op[OP_W-1 -: CLS_W] == LS_CLASS) begin
      case (op[4:0])
        5'b00000: acc = '{load: 1'b1, store: 1'b0, unsgn: 1'b0, size: SZ_BYTE};
        5'b00100: acc = '{load: 1'b1, store: 1'b0, unsgn: 1'b1, size: SZ_BYTE};
        5'b00001: acc = '{load: 1'b1, store: 1'b0, unsgn: 1'b0, size: SZ_HALF};
        5'b00101: acc = '{load: 1'b1, store: 1'b0, unsgn: 1'b1, size: SZ_HALF};
        5'b00011: acc = '{load: 1'b1, store: 1'b0, unsgn: 1'b0, size: SZ_WORD};
        5'b01000: acc = '{load: 1'b0, store: 1'b1, unsgn: 1'b0, size: SZ_BYTE};
        5'b01001: acc = '{load: 1'b0, store: 1'b1, unsgn: 1'b0, size: SZ_HALF};
        5'b01011: acc = '{load: 1'b0, store: 1'b1, unsgn: 1'b0, size: SZ_WORD};
        default: ;
      endcase
    end
    // R3: a decoded access is never both a load and a store
    assert_one_kind_R3: assert (!(acc.load && acc.store))
      else $error("decode produced load and store together");
  end
endmodule

// File: rtl/mstage_lane.sv
module mstage_lane
  import mstage_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int OFF_W = $clog2(LANES)
) (
  input  acc_t              acc,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] store_val,
  output logic [LANES-1:0]  lane,
  output logic [DATA_W-1:0] wdata
);
  localparam int HALF_W = 2 * BYTE_W;

  always_comb begin
    lane  = '0;
    wdata = '0;
    if (acc.load || acc.store) begin
      for (int i = 0; i < LANES; i++) begin
        case (acc.size)
          SZ_BYTE: lane[i] = (i == LANES - 1 - int'(off));
          SZ_HALF: lane[i] = off[OFF_W-1] ? (i < LANES / 2) : (i >= LANES / 2);
          default: lane[i] = 1'b1;
        endcase
      end
    end
    if (acc.store) begin
      case (acc.size)
        SZ_BYTE: wdata = {LANES{store_val[BYTE_W-1:0]}};
        SZ_HALF: wdata = {(LANES / 2){store_val[HALF_W-1:0]}};
        default: wdata = store_val;
      endcase
    end
    // R4: an active access enables one, two or all lanes
    if (acc.load || acc.store) begin
      assert_lane_shape_R4: assert ($countones(lane) == 1 || $countones(lane) == 2
                                    || $countones(lane) == LANES)
        else $error("lane mask has an illegal width");
    end
  end
endmodule

// File: rtl/mstage_extract.sv
module mstage_extract
  import mstage_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int OFF_W = $clog2(LANES)
) (
  input  acc_t              acc,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] value
);
  localparam int HALF_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] pick_b;
  logic [HALF_W-1:0] pick_h;

  always_comb begin
    pick_b = rd_word[(LANES - 1 - int'(off)) * BYTE_W +: BYTE_W];
    pick_h = off[OFF_W-1] ? rd_word[HALF_W-1:0] : rd_word[DATA_W-1 -: HALF_W];
    case (acc.size)
      SZ_BYTE: value = {{(DATA_W - BYTE_W){pick_b[BYTE_W-1] & ~acc.unsgn}}, pick_b};
      SZ_HALF: value = {{(DATA_W - HALF_W){pick_h[HALF_W-1] & ~acc.unsgn}}, pick_h};
      default: value = rd_word;
    endcase
    // R7: zero extension leaves the upper bits clear
    if (acc.load && acc.unsgn && acc.size == SZ_BYTE) begin
      assert_unsigned_top_R7: assert (value[DATA_W-1:BYTE_W] == '0)
        else $error("unsigned byte load carries upper bits");
    end
  end
endmodule

// File: rtl/mstage_top.sv
module mstage_top
  import mstage_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5,
  parameter int OP_W   = 8,
  parameter int BYTE_W = 8,
  localparam int LANES = DATA_W / BYTE_W,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              rst,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] store_val_i,
  input  logic [REG_AW-1:0] dst_i,
  input  logic              dst_we_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic              hilo_we_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic [REG_AW-1:0] dst_o,
  output logic              dst_we_o,
  output logic [DATA_W-1:0] result_o,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] lo_o,
  output logic              hilo_we_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic              mem_ce_o,
  output logic              mem_we_o,
  output logic [LANES-1:0]  mem_lane_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  acc_t              acc;
  logic [LANES-1:0]  lane;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] ld_value;
  logic [OFF_W-1:0]  off;

  assign off = addr_i[OFF_W-1:0];

  mstage_decode #(.OP_W(OP_W)) u_dec (.op(op_i), .acc(acc));

  mstage_lane #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_lane (
    .acc(acc), .off(off), .store_val(store_val_i), .lane(lane), .wdata(wdata)
  );

  mstage_extract #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ext (
    .acc(acc), .off(off), .rd_word(rd_word_i), .value(ld_value)
  );

  always_comb begin
    dst_o       = '0;
    dst_we_o    = 1'b0;
    result_o    = '0;
    hi_o        = '0;
    lo_o        = '0;
    hilo_we_o   = 1'b0;
    mem_addr_o  = '0;
    mem_ce_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_lane_o  = '0;
    mem_wdata_o = '0;
    if (!rst) begin
      dst_o     = dst_i;
      dst_we_o  = dst_we_i;
      result_o  = result_i;
      hi_o      = hi_i;
      lo_o      = lo_i;
      hilo_we_o = hilo_we_i;
      if (acc.load || acc.store) begin
        mem_addr_o = addr_i;
        mem_ce_o   = 1'b1;
        mem_lane_o = lane;
      end
      if (acc.store) begin
        mem_we_o    = 1'b1;
        mem_wdata_o = wdata;
        dst_we_o    = 1'b0;
      end
      if (acc.load) begin
        dst_we_o = 1'b1;
        result_o = ld_value;
      end
    end
  end

  always_comb begin
    // R1: reset keeps memory idle
    if (rst) begin
      assert_reset_quiet_R1: assert (!mem_ce_o && !mem_we_o && mem_lane_o == '0)
        else $error("memory active during reset");
    end
    // R8: a write never also writes a register, and needs chip enable
    if (mem_we_o) begin
      assert_store_no_regwrite_R8: assert (!dst_we_o && mem_ce_o)
        else $error("store drives register write or lacks chip enable");
    end
  end
endmodule

// File: tb/sim_mstage_top.sv
module sim_mstage_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  op_i;
  logic [31:0] addr_i, store_val_i, result_i, hi_i, lo_i, rd_word_i;
  logic [4:0]  dst_i;
  logic        dst_we_i, hilo_we_i;
  logic [4:0]  dst_o;
  logic        dst_we_o, hilo_we_o, mem_ce_o, mem_we_o;
  logic [31:0] result_o, hi_o, lo_o, mem_addr_o, mem_wdata_o;
  logic [3:0]  mem_lane_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  mstage_top u0 (
    .rst(rst), .op_i(op_i), .addr_i(addr_i), .store_val_i(store_val_i),
    .dst_i(dst_i), .dst_we_i(dst_we_i), .result_i(result_i), .hi_i(hi_i),
    .lo_i(lo_i), .hilo_we_i(hilo_we_i), .rd_word_i(rd_word_i),
    .dst_o(dst_o), .dst_we_o(dst_we_o), .result_o(result_o), .hi_o(hi_o),
    .lo_o(lo_o), .hilo_we_o(hilo_we_o), .mem_addr_o(mem_addr_o),
    .mem_ce_o(mem_ce_o), .mem_we_o(mem_we_o), .mem_lane_o(mem_lane_o),
    .mem_wdata_o(mem_wdata_o)
  );

  typedef struct packed {
    logic [7:0]  op;
    logic [31:0] addr;
    logic [31:0] sv;
    logic [31:0] rw;
    logic [31:0] e_res;
    logic [3:0]  e_lane;
    logic [31:0] e_wd;
    logic        e_we;
    logic        e_dwe;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{8'hE8, 32'h3, 32'h0000eeff, 32'h0, 32'h12345678, 4'b0001, 32'hffffffff, 1'b1, 1'b0},
    '{8'hE8, 32'h2, 32'h000000ee, 32'h0, 32'h12345678, 4'b0010, 32'heeeeeeee, 1'b1, 1'b0},
    '{8'hE8, 32'h0, 32'h000000cc, 32'h0, 32'h12345678, 4'b1000, 32'hcccccccc, 1'b1, 1'b0},
    '{8'hE0, 32'h3, 32'h0, 32'hccddeeff, 32'hffffffff, 4'b0001, 32'h0, 1'b0, 1'b1},
    '{8'hE4, 32'h2, 32'h0, 32'hccddeeff, 32'h000000ee, 4'b0010, 32'h0, 1'b0, 1'b1},
    '{8'hE0, 32'h1, 32'h0, 32'hccddeeff, 32'hffffffdd, 4'b0100, 32'h0, 1'b0, 1'b1},
    '{8'hE0, 32'h0, 32'h0, 32'h7fddeeff, 32'h0000007f, 4'b1000, 32'h0, 1'b0, 1'b1},
    '{8'hE9, 32'h4, 32'h0000aabb, 32'h0, 32'h12345678, 4'b1100, 32'haabbaabb, 1'b1, 1'b0},
    '{8'hE9, 32'h6, 32'h00008899, 32'h0, 32'h12345678, 4'b0011, 32'h88998899, 1'b1, 1'b0},
    '{8'hE1, 32'h4, 32'h0, 32'haabb8899, 32'hffffaabb, 4'b1100, 32'h0, 1'b0, 1'b1},
    '{8'hE5, 32'h4, 32'h0, 32'haabb8899, 32'h0000aabb, 4'b1100, 32'h0, 1'b0, 1'b1},
    '{8'hE1, 32'h6, 32'h0, 32'haabb8899, 32'hffff8899, 4'b0011, 32'h0, 1'b0, 1'b1},
    '{8'hE5, 32'h6, 32'h0, 32'haabb8899, 32'h00008899, 4'b0011, 32'h0, 1'b0, 1'b1},
    '{8'hEB, 32'h8, 32'h44556677, 32'h0, 32'h12345678, 4'b1111, 32'h44556677, 1'b1, 1'b0},
    '{8'hE3, 32'h8, 32'h0, 32'h44556677, 32'h44556677, 4'b1111, 32'h0, 1'b0, 1'b1},
    '{8'hE3, 32'hb, 32'h0, 32'h44556677, 32'h44556677, 4'b1111, 32'h0, 1'b0, 1'b1},
    '{8'hE1, 32'h7, 32'h0, 32'haabb8899, 32'hffff8899, 4'b0011, 32'h0, 1'b0, 1'b1}
  };

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", what, got, exp);
    end
  endtask

  task automatic settle;
    @(negedge clk);
    #5;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; op_i = 8'hE3; addr_i = 32'h8; store_val_i = 32'hdeadbeef;
    dst_i = 5'h11; dst_we_i = 1'b1; result_i = 32'h12345678;
    hi_i = 32'h0000000a; lo_i = 32'h0000000b; hilo_we_i = 1'b1; rd_word_i = 32'h55aa55aa;
    settle();
    // R1: reset forces everything to zero even with a load present
    chk("R1 ce", {31'b0, mem_ce_o}, 32'h0);
    chk("R1 we", {31'b0, mem_we_o}, 32'h0);
    chk("R1 lane", {28'b0, mem_lane_o}, 32'h0);
    chk("R1 dst_we", {31'b0, dst_we_o}, 32'h0);
    chk("R1 result", result_o, 32'h0);
    chk("R1 addr", mem_addr_o, 32'h0);
    chk("R1 hi", hi_o, 32'h0);
    chk("R1 hilo_we", {31'b0, hilo_we_o}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      op_i = TBL[i].op; addr_i = TBL[i].addr; store_val_i = TBL[i].sv;
      rd_word_i = TBL[i].rw; dst_we_i = TBL[i].op[3];
      #5;
      // R3 R4 R5 R6 R7 R8 R9: per-vector lanes, data and flags
      chk($sformatf("R3 ce v%0d", i), {31'b0, mem_ce_o}, 32'h1);
      chk($sformatf("R3 addr v%0d", i), mem_addr_o, TBL[i].addr);
      chk($sformatf("R4/R5/R6 lane v%0d", i), {28'b0, mem_lane_o}, {28'b0, TBL[i].e_lane});
      chk($sformatf("R7/R9 result v%0d", i), result_o, TBL[i].e_res);
      chk($sformatf("R8 wdata v%0d", i), mem_wdata_o, TBL[i].e_wd);
      chk($sformatf("R8/R9 we v%0d", i), {31'b0, mem_we_o}, {31'b0, TBL[i].e_we});
      chk($sformatf("R8/R9 dst_we v%0d", i), {31'b0, dst_we_o}, {31'b0, TBL[i].e_dwe});
      chk($sformatf("R3 hi v%0d", i), hi_o, 32'h0000000a);
      chk($sformatf("R3 lo v%0d", i), lo_o, 32'h0000000b);
    end

    // R2: an arithmetic-class code passes through, memory idle
    @(negedge clk);
    op_i = 8'h21; addr_i = 32'h40; dst_we_i = 1'b1; dst_i = 5'h07; hilo_we_i = 1'b0;
    #5;
    chk("R2 ce", {31'b0, mem_ce_o}, 32'h0);
    chk("R2 lane", {28'b0, mem_lane_o}, 32'h0);
    chk("R2 addr", mem_addr_o, 32'h0);
    chk("R2 result", result_o, 32'h12345678);
    chk("R2 dst", {27'b0, dst_o}, 32'h7);
    chk("R2 dst_we", {31'b0, dst_we_o}, 32'h1);
    chk("R2 hilo_we", {31'b0, hilo_we_o}, 32'h0);

    // R2: an unlisted code in the load/store class is also non-memory
    @(negedge clk);
    op_i = 8'hE2; dst_we_i = 1'b0;
    #5;
    chk("R2 unlisted ce", {31'b0, mem_ce_o}, 32'h0);
    chk("R2 unlisted we", {31'b0, mem_we_o}, 32'h0);
    chk("R2 unlisted wdata", mem_wdata_o, 32'h0);
    chk("R2 unlisted dst_we", {31'b0, dst_we_o}, 32'h0);

    // R6: word store at an offset of 2 still writes all lanes
    @(negedge clk);
    op_i = 8'hEB; addr_i = 32'h12; store_val_i = 32'hcafef00d;
    #5;
    chk("R6 lane off2", {28'b0, mem_lane_o}, 32'hf);
    chk("R6 wdata off2", mem_wdata_o, 32'hcafef00d);

    // R1: reset reasserted mid-stream clears a store
    @(negedge clk);
    rst = 1'b1;
    #5;
    chk("R1 store under reset we", {31'b0, mem_we_o}, 32'h0);
    chk("R1 store under reset wdata", mem_wdata_o, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule